// File: doc/BRIEF.md
# Table-Driven Match Action Engine

This block sits behind an event detector that produces match packets: the identifier of the matcher that fired, an address and a data word. For every accepted packet the engine runs a short programmed routine. The routine is a run of entries from a small action table. The identifier of the matcher selects where the run starts and how long it is. Each entry names one operation: an ALU step, a memory load, a memory store or a no-op. It also names two operand sources, an ALU function and a destination, and it carries a 64-bit immediate. Operands come from the latched packet fields, from the last memory response, from the immediate or from a four-slot local register file. Results go to a local register or to a sticky interrupt flag, or they are discarded.

Software fills the table through a write port. It also sets, for each matcher, a start index and an entry count. The engine then runs on its own. It accepts a packet only while idle and steps a pointer and a down-counter through the entries. An ALU step or a store takes one cycle. A load holds the sequence until the memory response arrives. The next packet is taken once the last entry has completed. A typical routine compares a value loaded from memory with a packet field and raises the interrupt when the two differ.

Top module: `mae_engine`

## Requirements
- R1: After reset, pkt_ready is 1, irq is 0 and mem_req_valid is 0, and all local registers and the memory-response register read as zero.
- R2: An entry word is {op[78:77], in1[76:74], in2[73:71], fn[70:67], out[66:64], imm[63:0]}. A packet from matcher m runs the entries base[m], base[m]+1, … in order, for len[m] entries, and the index wraps modulo the table depth.
- R3: ALU function codes are 0 add, 1 in1−in2, 2 and, 3 or, 4 xor, 5 set-if-equal (result 1 or 0), 6 set-if-not-equal, 7 unsigned less-than (1 or 0), 8 shift left by in2[5:0], 9 logical shift right by in2[5:0] and 10 pass in1. Codes 11 to 15 give 0.
- R4: Source codes are 0 packet address (zero-extended), 1 packet data, 2 last memory response, 3 entry immediate, and 4 to 7 local registers 0 to 3. An operand reads values written by earlier entries.
- R5: Destination codes are 0 discard, 1 interrupt flag, 2 and 3 discard, and 4 to 7 local registers 0 to 3. A discarded result changes no register.
- R6: Op code 1 (load) issues one read request at address in1[ADDR_W-1:0]. The engine then waits for mem_resp_valid, however late it comes. The response data is written to the destination and to the memory-response register.
- R7: Op code 2 (store) issues one write request for one cycle, with address in1[ADDR_W-1:0] and write data in2, and it does not wait.
- R8: Writing a nonzero result to the interrupt flag sets irq. A zero result leaves irq unchanged. irq stays set until irq_clr, and a set in the same cycle as irq_clr wins.
- R9: pkt_ready is high only while idle. A packet whose entries are all ALU, store or no-op keeps pkt_ready low for exactly as many cycles as it has entries. A packet with zero entries leaves pkt_ready high.
- R10: Op code 3 (no-op) takes one cycle and changes no state.
- R11: At most one load is outstanding, and no request is issued while a load is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one action-table entry |
| cfg_idx | input | TBL_AW | Entry index to write |
| cfg_word | input | 79 | Entry word (layout in R2) |
| seq_we | input | 1 | Write start index and count for one matcher |
| seq_mu | input | MU_W | Matcher selected for the sequence write |
| seq_base | input | TBL_AW | First entry index |
| seq_len | input | TBL_AW+1 | Number of entries, 0 to TBL_DEPTH |
| pkt_valid | input | 1 | Match packet present |
| pkt_ready | output | 1 | Engine idle, packet taken when valid |
| pkt_mu | input | MU_W | Matcher identifier of the packet |
| pkt_addr | input | ADDR_W | Packet address field |
| pkt_data | input | DATA_W | Packet data field |
| mem_req_valid | output | 1 | Memory request this cycle |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_resp_valid | input | 1 | Read response present |
| mem_resp_data | input | DATA_W | Read response data |
| irq_clr | input | 1 | Clear the interrupt flag |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Two events can land in the same cycle: software clearing the interrupt, and an ALU entry writing the interrupt flag. The bench provokes this by raising irq_clr in exactly the cycle in which the first entry of a packet executes. It does so once with a nonzero result, where irq must remain 1, and once with a zero result, where the clear must take effect. Random routines mixing loads with variable response latency, stores and ALU steps are compared, store by store, against a sequential model of the table, and irq is compared after every packet.

// File: rtl/mae_pkg.sv
package mae_pkg;
   localparam int OP_W    = 2;
   localparam int SRC_W   = 3;
   localparam int FN_W    = 4;
   localparam int DST_W   = 3;
   localparam int IMM_W   = 64;
   localparam int ENTRY_W = OP_W + 2 * SRC_W + FN_W + DST_W + IMM_W;
   localparam int LOC_SLOTS = 4;

   localparam logic [OP_W-1:0] OP_ALU   = 2'd0;
   localparam logic [OP_W-1:0] OP_LOAD  = 2'd1;
   localparam logic [OP_W-1:0] OP_STORE = 2'd2;
   localparam logic [OP_W-1:0] OP_NOP   = 2'd3;

   localparam logic [SRC_W-1:0] SRC_ADDR = 3'd0;
   localparam logic [SRC_W-1:0] SRC_DATA = 3'd1;
   localparam logic [SRC_W-1:0] SRC_RESP = 3'd2;
   localparam logic [SRC_W-1:0] SRC_IMM  = 3'd3;

   localparam logic [FN_W-1:0] FN_ADD  = 4'd0;
   localparam logic [FN_W-1:0] FN_SUB  = 4'd1;
   localparam logic [FN_W-1:0] FN_AND  = 4'd2;
   localparam logic [FN_W-1:0] FN_OR   = 4'd3;
   localparam logic [FN_W-1:0] FN_XOR  = 4'd4;
   localparam logic [FN_W-1:0] FN_SEQ  = 4'd5;
   localparam logic [FN_W-1:0] FN_SNE  = 4'd6;
   localparam logic [FN_W-1:0] FN_SLTU = 4'd7;
   localparam logic [FN_W-1:0] FN_SLL  = 4'd8;
   localparam logic [FN_W-1:0] FN_SRL  = 4'd9;
   localparam logic [FN_W-1:0] FN_PASS = 4'd10;

   localparam logic [DST_W-1:0] DST_NONE = 3'd0;
   localparam logic [DST_W-1:0] DST_IRQ  = 3'd1;

   typedef struct packed {
      logic [OP_W-1:0]  op;
      logic [SRC_W-1:0] in1;
      logic [SRC_W-1:0] in2;
      logic [FN_W-1:0]  fn;
      logic [DST_W-1:0] dst;
      logic [IMM_W-1:0] imm;
   } entry_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXEC = 2'd1,
      ST_WAIT = 2'd2
   } seq_st_e;
endpackage

// File: rtl/mae_cfg_table.sv
module mae_cfg_table
   import mae_pkg::*;
#(
   parameter int TBL_DEPTH = 16,
   parameter int MU_N      = 4,
   localparam int TBL_AW   = $clog2(TBL_DEPTH),
   localparam int MU_W     = $clog2(MU_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TBL_AW-1:0] wr_idx,
   input  logic [ENTRY_W-1:0] wr_word,
   input  logic              seq_we,
   input  logic [MU_W-1:0]   seq_mu,
   input  logic [TBL_AW-1:0] seq_base,
   input  logic [TBL_AW:0]   seq_len,
   input  logic [TBL_AW-1:0] rd_idx,
   output entry_t            rd_entry,
   input  logic [MU_W-1:0]   look_mu,
   output logic [TBL_AW-1:0] look_base,
   output logic [TBL_AW:0]   look_len
);
   logic [ENTRY_W-1:0] row_q  [TBL_DEPTH];
   logic [TBL_AW-1:0]  base_q [MU_N];
   logic [TBL_AW:0]    len_q  [MU_N];

   for (genvar r = 0; r < TBL_DEPTH; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_q[r] <= '0;
         else if (wr_en && wr_idx == TBL_AW'(r))
            row_q[r] <= wr_word;
      end
   end

   for (genvar m = 0; m < MU_N; m++) begin : g_seq
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[m] <= '0;
            len_q[m]  <= '0;
         end else if (seq_we && seq_mu == MU_W'(m)) begin
            base_q[m] <= seq_base;
            len_q[m]  <= seq_len;
         end
      end
   end

   assign rd_entry  = entry_t'(row_q[rd_idx]);
   assign look_base = base_q[look_mu];
   assign look_len  = len_q[look_mu];
endmodule

// File: rtl/mae_loc_rf.sv
module mae_loc_rf
   import mae_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LOC_N  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_slot,
   input  logic [DATA_W-1:0] wr_val,
   output logic [LOC_SLOTS-1:0][DATA_W-1:0] rd_all
);
   for (genvar s = 0; s < LOC_SLOTS; s++) begin : g_slot
      if (s < LOC_N) begin : g_live
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               val_q <= '0;
            else if (wr_en && wr_slot == 2'(s))
               val_q <= wr_val;
         end
         assign rd_all[s] = val_q;
      end else begin : g_absent
         assign rd_all[s] = '0;
      end
   end
endmodule

// File: rtl/mae_opnd_sel.sv
module mae_opnd_sel
   import mae_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic [SRC_W-1:0]  sel,
   input  logic [ADDR_W-1:0] pkt_addr,
   input  logic [DATA_W-1:0] pkt_data,
   input  logic [DATA_W-1:0] resp,
   input  logic [DATA_W-1:0] imm,
   input  logic [LOC_SLOTS-1:0][DATA_W-1:0] loc,
   output logic [DATA_W-1:0] val
);
   always_comb begin
      unique case (sel)
         SRC_ADDR: val = DATA_W'(pkt_addr);
         SRC_DATA: val = pkt_data;
         SRC_RESP: val = resp;
         SRC_IMM:  val = imm;
         default:  val = loc[sel[1:0]];
      endcase
   end
endmodule

// File: rtl/mae_alu.sv
module mae_alu
   import mae_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter bit HAS_SHIFT = 1'b1,
   localparam int SH_W     = $clog2(DATA_W)
) (
   input  logic [FN_W-1:0]   fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] sh_l, sh_r;

   if (HAS_SHIFT) begin : g_shift
      assign sh_l = a << b[SH_W-1:0];
      assign sh_r = a >> b[SH_W-1:0];
   end else begin : g_noshift
      assign sh_l = '0;
      assign sh_r = '0;
   end

   always_comb begin
      unique case (fn)
         FN_ADD:  res = a + b;
         FN_SUB:  res = a - b;
         FN_AND:  res = a & b;
         FN_OR:   res = a | b;
         FN_XOR:  res = a ^ b;
         FN_SEQ:  res = DATA_W'(a == b);
         FN_SNE:  res = DATA_W'(a != b);
         FN_SLTU: res = DATA_W'(a < b);
         FN_SLL:  res = sh_l;
         FN_SRL:  res = sh_r;
         FN_PASS: res = a;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/mae_engine.sv
module mae_engine
   import mae_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int MU_N      = 4,
   parameter int TBL_DEPTH = 16,
   parameter int LOC_N     = 4,
   parameter bit HAS_SHIFT = 1'b1,
   localparam int TBL_AW   = $clog2(TBL_DEPTH),
   localparam int MU_W     = $clog2(MU_N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [TBL_AW-1:0]  cfg_idx,
   input  logic [ENTRY_W-1:0] cfg_word,
   input  logic               seq_we,
   input  logic [MU_W-1:0]    seq_mu,
   input  logic [TBL_AW-1:0]  seq_base,
   input  logic [TBL_AW:0]    seq_len,
   input  logic               pkt_valid,
   output logic               pkt_ready,
   input  logic [MU_W-1:0]    pkt_mu,
   input  logic [ADDR_W-1:0]  pkt_addr,
   input  logic [DATA_W-1:0]  pkt_data,
   output logic               mem_req_valid,
   output logic               mem_req_we,
   output logic [ADDR_W-1:0]  mem_req_addr,
   output logic [DATA_W-1:0]  mem_req_wdata,
   input  logic               mem_resp_valid,
   input  logic [DATA_W-1:0]  mem_resp_data,
   input  logic               irq_clr,
   output logic               irq
);
   if (DATA_W < ADDR_W || DATA_W > IMM_W || DATA_W < 8) begin : g_bad_data_w
      $error("mae_engine: DATA_W must lie in [max(8,ADDR_W), 64]");
   end
   if (TBL_DEPTH < 2 || (1 << TBL_AW) != TBL_DEPTH) begin : g_bad_depth
      $error("mae_engine: TBL_DEPTH must be a power of two, at least 2");
   end
   if (MU_N < 2 || (1 << MU_W) != MU_N) begin : g_bad_mu
      $error("mae_engine: MU_N must be a power of two, at least 2");
   end
   if (LOC_N < 1 || LOC_N > LOC_SLOTS) begin : g_bad_loc
      $error("mae_engine: LOC_N must lie in [1, 4]");
   end

   seq_st_e           st_q, st_d;
   logic [TBL_AW-1:0] ptr_q;
   logic [TBL_AW:0]   ctr_q;
   logic [ADDR_W-1:0] paddr_q;
   logic [DATA_W-1:0] pdata_q;
   logic [DATA_W-1:0] resp_q;
   logic              irq_q;

   entry_t            ent;
   logic [TBL_AW-1:0] look_base;
   logic [TBL_AW:0]   look_len;
   logic [LOC_SLOTS-1:0][DATA_W-1:0] loc_all;
   logic [DATA_W-1:0] opa, opb, alu_res, imm_v;

   logic              accept, adv, dst_we, resp_cap, req_v, req_we;
   logic [DATA_W-1:0] dst_val;
   logic              loc_we, irq_set;

   mae_cfg_table #(.TBL_DEPTH(TBL_DEPTH), .MU_N(MU_N)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_word  (cfg_word),
      .seq_we   (seq_we),
      .seq_mu   (seq_mu),
      .seq_base (seq_base),
      .seq_len  (seq_len),
      .rd_idx   (ptr_q),
      .rd_entry (ent),
      .look_mu  (pkt_mu),
      .look_base(look_base),
      .look_len (look_len)
   );

   assign imm_v = ent.imm[DATA_W-1:0];

   mae_opnd_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel_a (
      .sel(ent.in1), .pkt_addr(paddr_q), .pkt_data(pdata_q),
      .resp(resp_q), .imm(imm_v), .loc(loc_all), .val(opa)
   );

   mae_opnd_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel_b (
      .sel(ent.in2), .pkt_addr(paddr_q), .pkt_data(pdata_q),
      .resp(resp_q), .imm(imm_v), .loc(loc_all), .val(opb)
   );

   mae_alu #(.DATA_W(DATA_W), .HAS_SHIFT(HAS_SHIFT)) u_alu (
      .fn(ent.fn), .a(opa), .b(opb), .res(alu_res)
   );

   mae_loc_rf #(.DATA_W(DATA_W), .LOC_N(LOC_N)) u_loc (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (loc_we),
      .wr_slot(ent.dst[1:0]),
      .wr_val (dst_val),
      .rd_all (loc_all)
   );

   assign accept = (st_q == ST_IDLE) && pkt_valid;

   always_comb begin
      st_d     = st_q;
      adv      = 1'b0;
      dst_we   = 1'b0;
      dst_val  = alu_res;
      resp_cap = 1'b0;
      req_v    = 1'b0;
      req_we   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (accept && look_len != '0)
               st_d = ST_EXEC;
         end
         ST_EXEC: begin
            unique case (ent.op)
               OP_ALU: begin
                  dst_we = 1'b1;
                  adv    = 1'b1;
               end
               OP_LOAD: begin
                  req_v = 1'b1;
                  st_d  = ST_WAIT;
               end
               OP_STORE: begin
                  req_v  = 1'b1;
                  req_we = 1'b1;
                  adv    = 1'b1;
               end
               default: adv = 1'b1;
            endcase
         end
         ST_WAIT: begin
            if (mem_resp_valid) begin
               dst_we   = 1'b1;
               dst_val  = mem_resp_data;
               resp_cap = 1'b1;
               adv      = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (adv)
         st_d = (ctr_q == (TBL_AW+1)'(1)) ? ST_IDLE : ST_EXEC;
   end

   assign loc_we  = dst_we && ent.dst[2];
   assign irq_set = dst_we && (ent.dst == DST_IRQ) && (dst_val != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ptr_q   <= '0;
         ctr_q   <= '0;
         paddr_q <= '0;
         pdata_q <= '0;
         resp_q  <= '0;
         irq_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            ptr_q   <= look_base;
            ctr_q   <= look_len;
            paddr_q <= pkt_addr;
            pdata_q <= pkt_data;
         end else if (adv) begin
            ptr_q <= ptr_q + 1'b1;
            ctr_q <= ctr_q - 1'b1;
         end
         if (resp_cap)
            resp_q <= mem_resp_data;
         if (irq_set)
            irq_q <= 1'b1;
         else if (irq_clr)
            irq_q <= 1'b0;
      end
   end

   assign pkt_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = req_v;
   assign mem_req_we    = req_we;
   assign mem_req_addr  = opa[ADDR_W-1:0];
   assign mem_req_wdata = opb;
   assign irq           = irq_q;
endmodule

// File: rtl/mae_engine_chk.sv
module mae_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic pkt_ready,
   input logic mem_req_valid,
   input logic mem_req_we,
   input logic mem_resp_valid,
   input logic irq_clr,
   input logic irq
);
   logic load_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         load_pend <= 1'b0;
      else if (mem_req_valid && !mem_req_we)
         load_pend <= 1'b1;
      else if (mem_resp_valid)
         load_pend <= 1'b0;
   end

   AST_ONE_LOAD_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !load_pend); // R11
   AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_we |-> mem_req_valid); // R7
   AST_WAIT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      load_pend |-> !pkt_ready); // R6
   AST_IDLE_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |-> !mem_req_valid); // R9
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq); // R8
   AST_IRQ_RISES_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !$past(pkt_ready)); // R8
endmodule

bind mae_engine mae_engine_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pkt_ready     (pkt_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_we    (mem_req_we),
   .mem_resp_valid(mem_resp_valid),
   .irq_clr       (irq_clr),
   .irq           (irq)
);

// File: tb/mae_engine_bench.sv
`timescale 1ns/1ps
module mae_engine_bench;
   localparam int AW = 32;
   localparam int DW = 64;
   localparam int DEPTH = 16;
   localparam int MUS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [3:0] cfg_idx = '0;
   logic [78:0] cfg_word = '0;
   logic seq_we = 1'b0;
   logic [1:0] seq_mu = '0;
   logic [3:0] seq_base = '0;
   logic [4:0] seq_len = '0;
   logic pkt_valid = 1'b0;
   logic pkt_ready;
   logic [1:0] pkt_mu = '0;
   logic [AW-1:0] pkt_addr = '0;
   logic [DW-1:0] pkt_data = '0;
   logic mem_req_valid, mem_req_we;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata;
   logic mem_resp_valid = 1'b0;
   logic [DW-1:0] mem_resp_data = '0;
   logic irq_clr = 1'b0;
   logic irq;

   always #5 clk = ~clk;

   mae_engine u_mae_engine (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
      .seq_we(seq_we), .seq_mu(seq_mu), .seq_base(seq_base), .seq_len(seq_len),
      .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_mu(pkt_mu),
      .pkt_addr(pkt_addr), .pkt_data(pkt_data),
      .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
      .irq_clr(irq_clr), .irq(irq)
   );

   int n_chk = 0;
   int n_bad = 0;
   string cur_tag = "R1";

   // bench copies of the configuration and model state
   logic [78:0] b_tab [DEPTH];
   int b_base [MUS];
   int b_len  [MUS];
   logic [DW-1:0] m_loc [4];
   logic [DW-1:0] m_resp;
   logic m_irq;
   logic [DW-1:0] m_mem [256];
   logic [DW-1:0] d_mem [256];
   logic [AW-1:0] exp_a [$];
   logic [DW-1:0] exp_d [$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   function automatic logic [DW-1:0] ref_alu(input logic [3:0] fn,
                                            input logic [DW-1:0] a, input logic [DW-1:0] b);
      case (fn)
         4'd0: return a + b;
         4'd1: return a - b;
         4'd2: return a & b;
         4'd3: return a | b;
         4'd4: return a ^ b;
         4'd5: return (a == b) ? 64'd1 : 64'd0;
         4'd6: return (a != b) ? 64'd1 : 64'd0;
         4'd7: return (a < b) ? 64'd1 : 64'd0;
         4'd8: return a << b[5:0];
         4'd9: return a >> b[5:0];
         4'd10: return a;
         default: return '0;
      endcase
   endfunction

   function automatic logic [DW-1:0] ref_src(input logic [2:0] s, input logic [AW-1:0] a,
                                            input logic [DW-1:0] d, input logic [DW-1:0] imm);
      case (s)
         3'd0: return DW'(a);
         3'd1: return d;
         3'd2: return m_resp;
         3'd3: return imm;
         default: return m_loc[s[1:0]];
      endcase
   endfunction

   task automatic ref_write(input logic [2:0] dst, input logic [DW-1:0] v);
      if (dst == 3'd1 && v != '0) m_irq = 1'b1;
      if (dst[2]) m_loc[dst[1:0]] = v;
   endtask

   // sequential model of one packet; cyc is -1 when a load makes timing variable
   task automatic run_model(input int mu, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit clr_first, output int cyc);
      cyc = b_len[mu];
      if (clr_first) m_irq = 1'b0;
      for (int k = 0; k < b_len[mu]; k++) begin
         logic [78:0] w;
         logic [DW-1:0] x, y;
         w = b_tab[(b_base[mu] + k) % DEPTH];
         x = ref_src(w[76:74], a, d, w[63:0]);
         y = ref_src(w[73:71], a, d, w[63:0]);
         case (w[78:77])
            2'd0: ref_write(w[66:64], ref_alu(w[70:67], x, y));
            2'd1: begin
               m_resp = m_mem[x[7:0]];
               ref_write(w[66:64], m_resp);
               cyc = -1;
            end
            2'd2: begin
               exp_a.push_back(x[AW-1:0]);
               exp_d.push_back(y);
               m_mem[x[7:0]] = y;
            end
            default: ;
         endcase
      end
   endtask

   task automatic put_entry(input int idx, input logic [1:0] op, input logic [2:0] i1,
                            input logic [2:0] i2, input logic [3:0] fn, input logic [2:0] dst,
                            input logic [63:0] imm);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_idx = 4'(idx);
      cfg_word = {op, i1, i2, fn, dst, imm};
      b_tab[idx] = cfg_word;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic put_seq(input int mu, input int base, input int len);
      @(negedge clk);
      seq_we = 1'b1;
      seq_mu = 2'(mu);
      seq_base = 4'(base);
      seq_len = 5'(len);
      b_base[mu] = base;
      b_len[mu] = len;
      @(negedge clk);
      seq_we = 1'b0;
   endtask

   task automatic send(input int mu, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit clr_first);
      int cyc, busy;
      @(negedge clk);
      while (!pkt_ready) @(negedge clk);
      run_model(mu, a, d, clr_first, cyc);
      pkt_valid = 1'b1;
      pkt_mu = 2'(mu);
      pkt_addr = a;
      pkt_data = d;
      @(negedge clk);
      pkt_valid = 1'b0;
      if (clr_first) begin
         irq_clr = 1'b1;
         @(negedge clk);
         irq_clr = 1'b0;
         busy = 1;
      end else begin
         busy = 0;
      end
      while (!pkt_ready) begin
         busy++;
         @(negedge clk);
      end
      if (cyc >= 0)
         chk(busy == cyc, "R9", "busy cycles", DW'(busy), DW'(cyc));
      chk(irq == m_irq, cur_tag, "irq after packet", DW'(irq), DW'(m_irq));
      chk(exp_a.size() == 0, "R2", "stores left unissued", DW'(exp_a.size()), 64'd0);
      exp_a.delete();
      exp_d.delete();
   endtask

   task automatic do_clear();
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      m_irq = 1'b0;
      chk(irq == 1'b0, "R8", "irq after clear", DW'(irq), 64'd0);
   endtask

   // memory model and store comparison, all at the falling edge
   int resp_cnt = 0;
   always @(negedge clk) begin
      mem_resp_valid <= 1'b0;
      if (resp_cnt > 0) begin
         resp_cnt = resp_cnt - 1;
         if (resp_cnt == 0) mem_resp_valid <= 1'b1;
      end
      if (rst_n && mem_req_valid) begin
         if (mem_req_we) begin
            d_mem[mem_req_addr[7:0]] = mem_req_wdata;
            if (exp_a.size() == 0) begin
               chk(1'b0, "R7", "unexpected store", DW'(mem_req_addr), 64'd0);
            end else begin
               chk(mem_req_addr == exp_a[0], cur_tag, "store address", DW'(mem_req_addr), DW'(exp_a[0]));
               chk(mem_req_wdata == exp_d[0], cur_tag, "store data", mem_req_wdata, exp_d[0]);
               void'(exp_a.pop_front());
               void'(exp_d.pop_front());
            end
         end else begin
            mem_resp_data <= d_mem[mem_req_addr[7:0]];
            resp_cnt = 1 + int'($urandom_range(0, 3));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R9", "watchdog expired", 64'd1, 64'd0);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      for (int i = 0; i < 256; i++) begin
         m_mem[i] = (64'(i) * 64'h0101_0101_0101_0101) ^ 64'(i);
         d_mem[i] = m_mem[i];
      end
      for (int i = 0; i < 4; i++) m_loc[i] = '0;
      for (int i = 0; i < DEPTH; i++) b_tab[i] = '0;
      for (int i = 0; i < MUS; i++) begin b_base[i] = 0; b_len[i] = 0; end
      m_resp = '0;
      m_irq = 1'b0;

      repeat (3) @(negedge clk);
      chk(pkt_ready == 1'b1, "R1", "ready in reset", DW'(pkt_ready), 64'd1);
      chk(irq == 1'b0, "R1", "irq in reset", DW'(irq), 64'd0);
      chk(mem_req_valid == 1'b0, "R1", "request in reset", DW'(mem_req_valid), 64'd0);
      rst_n = 1'b1;

      // R1: registers read as zero after reset
      cur_tag = "R1";
      put_entry(0, 2'd2, 3'd3, 3'd4, 4'd0, 3'd0, 64'h60);
      put_entry(1, 2'd2, 3'd3, 3'd2, 4'd0, 3'd0, 64'h61);
      put_seq(0, 0, 2);
      send(0, 32'h0, 64'h0, 1'b0);

      // R3: set-if-equal into local 3, stored out
      cur_tag = "R3";
      put_entry(0, 2'd0, 3'd0, 3'd1, 4'd5, 3'd7, 64'h0);
      put_entry(1, 2'd2, 3'd3, 3'd7, 4'd0, 3'd0, 64'h20);
      send(0, 32'h5, 64'h5, 1'b0);
      send(0, 32'h5, 64'h6, 1'b0);

      // R4 and R5: sources, discard destination leaves local 0 untouched
      cur_tag = "R5";
      put_entry(2, 2'd0, 3'd1, 3'd0, 4'd10, 3'd4, 64'h0);
      put_entry(3, 2'd0, 3'd4, 3'd3, 4'd0, 3'd0, 64'h7);
      put_entry(4, 2'd2, 3'd3, 3'd4, 4'd0, 3'd0, 64'h30);
      put_entry(5, 2'd2, 3'd0, 3'd3, 4'd0, 3'd2, 64'hABC);
      put_seq(1, 2, 4);
      cur_tag = "R4";
      send(1, 32'h44, 64'h1234, 1'b0);

      // R6: load into local 1, then memory-response source
      cur_tag = "R6";
      put_entry(6, 2'd1, 3'd3, 3'd0, 4'd0, 3'd5, 64'h30);
      put_entry(7, 2'd2, 3'd0, 3'd5, 4'd0, 3'd0, 64'h0);
      put_entry(8, 2'd2, 3'd3, 3'd2, 4'd0, 3'd0, 64'h31);
      put_seq(2, 6, 3);
      send(2, 32'h50, 64'h0, 1'b0);

      // R8: interrupt set, clear, zero write, same-cycle clear
      cur_tag = "R8";
      put_entry(9, 2'd0, 3'd0, 3'd1, 4'd6, 3'd1, 64'h0);
      put_seq(3, 9, 1);
      send(3, 32'h1, 64'h2, 1'b0);
      do_clear();
      send(3, 32'h4, 64'h4, 1'b0);
      send(3, 32'h1, 64'h2, 1'b0);
      send(3, 32'h1, 64'h2, 1'b1);
      send(3, 32'h7, 64'h7, 1'b1);
      do_clear();

      // R10 and R9: no-ops interleaved with ALU steps, zero-length packet
      cur_tag = "R10";
      put_entry(10, 2'd0, 3'd6, 3'd3, 4'd0, 3'd6, 64'h1);
      put_entry(11, 2'd3, 3'd0, 3'd0, 4'd0, 3'd6, 64'h0);
      put_entry(12, 2'd0, 3'd6, 3'd3, 4'd0, 3'd6, 64'h1);
      put_entry(13, 2'd3, 3'd0, 3'd0, 4'd0, 3'd6, 64'h0);
      put_entry(14, 2'd2, 3'd3, 3'd6, 4'd0, 3'd0, 64'h40);
      put_seq(0, 10, 5);
      send(0, 32'h0, 64'h0, 1'b0);
      cur_tag = "R9";
      put_seq(0, 3, 0);
      send(0, 32'h9, 64'h9, 1'b0);

      // R2: index wraps past the last entry
      cur_tag = "R2";
      put_entry(15, 2'd0, 3'd3, 3'd0, 4'd10, 3'd7, 64'h9);
      put_seq(1, 14, 4);
      send(1, 32'h3, 64'h3, 1'b0);

      // constrained random routines
      cur_tag = "R2";
      for (int ph = 0; ph < 6; ph++) begin
         for (int i = 0; i < DEPTH; i++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            put_entry(i, op, 3'($urandom), 3'($urandom), 4'($urandom_range(0, 15)),
                      3'($urandom), {32'($urandom), 32'($urandom)});
         end
         for (int m = 0; m < MUS; m++)
            put_seq(m, int'($urandom_range(0, DEPTH - 1)), int'($urandom_range(0, DEPTH)));
         for (int p = 0; p < 40; p++) begin
            if ($urandom_range(0, 3) == 0) do_clear();
            send(int'($urandom_range(0, MUS - 1)),
                 ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 255)) : 32'($urandom),
                 {32'($urandom), 32'($urandom_range(0, 3))}, 1'b0);
         end
      end

      summary();
      $finish;
   end
endmodule